// File: doc/BRIEF.md
# Multi-Phase Integrate-and-Dump Filter

This block is a matched filter for a binary baseband stream that arrives at eight samples per symbol. An example is a 134.4 symbol/s signal resampled to 1075.2 Hz. Each sample is signed, carries a valid strobe and is added into eight running sums at once. Each sum is tied to one possible symbol-start offset. When the window of one offset has taken in eight consecutive samples, the block emits that sum with its offset index and clears the sum for the next window.

The block does not recover symbol timing. One valid sample closes exactly one window, so after start-up every accepted sample yields one result. The results form eight interleaved streams. A later stage picks the best offset or drops the results that repeat across offsets. Samples-per-symbol and sample width are parameters. The sum width is derived so that a full window of full-scale samples cannot overflow.

Top module: `multiphase_intdump`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `res_valid` is 0.
- R2: `res_valid` pulses high for exactly one cycle, in the cycle after the clock edge that accepted the sample closing a window. It never goes high after a cycle in which `smp_valid` was 0.
- R3: Sums are exact at full scale. Eight samples of 32767 give 262136, and eight samples of -32768 give -262144, in the 19-bit signed `res_sum`.
- R4: `res_sum` equals the arithmetic sum of the 8 consecutive accepted samples that make up the window. The window starts at the accepted sample whose index since reset, taken modulo 8, equals `res_phase`.
- R5: `res_phase` is the start offset of the reported window, from 0 to 7. The window that closes on the accepted sample with index n since reset, counting from 0, reports phase (n+1) mod 8. Consecutive results therefore step the phase by one modulo 8.
- R6: No result is produced for the first 7 accepted samples after reset. The 8th accepted sample gives the first result, which has phase 0.
- R7: A cycle with `smp_valid` = 0 has no effect. No result is issued, and later results are the same as they would be with the idle cycle removed, whatever value `smp_data` holds.
- R8: Asserting reset in the middle of a stream discards all partial sums and the offset count. After reset, behaviour follows R6 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 16 | Signed input sample |
| res_valid | output | 1 | One-cycle result pulse |
| res_sum | output | 19 | Signed eight-sample sum |
| res_phase | output | 3 | Start offset of the reported window |

## Verification
The hardest case to reach from the ports is the idle cycle. Data that is not valid must leave all eight partial sums untouched and must not move the offset, and a wrong result only shows up several samples later. The stimulus places idle cycles carrying large, non-zero junk data between valid samples. A reference model, which never sees those cycles, then checks every later sum and phase. A reset is also applied partway through a window, so that partial sums in every lane are dropped at once and the start-up gap has to reappear.

// File: rtl/mpid_pkg.sv
package mpid_pkg;

    localparam int DEF_SAMPLE_W = 16;
    localparam int DEF_SPS      = 8;

    // per-lane control derived from the shared offset counter
    typedef struct packed {
        logic take;   // a valid sample is present
        logic open;   // this lane's window begins with this sample
        logic shut;   // this lane's window ends with this sample
    } lane_ctl_t;

    function automatic int sum_width(input int sample_w, input int sps);
        return sample_w + $clog2(sps);
    endfunction

endpackage

// File: rtl/mpid_phase_ctr.sv
module mpid_phase_ctr #(
    parameter int SPS  = mpid_pkg::DEF_SPS,
    localparam int PH_W = $clog2(SPS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            take,
    output logic [PH_W-1:0] pos,
    output logic [SPS-1:0]  open_vec,
    output logic [SPS-1:0]  shut_vec
);
    logic [PH_W-1:0] pos_q;
    logic [PH_W-1:0] pos_next;

    assign pos_next = pos_q + PH_W'(1);
    assign pos      = pos_q;

    always_ff @(posedge clk) begin
        if (rst)       pos_q <= '0;
        else if (take) pos_q <= pos_next;
    end

    for (genvar i = 0; i < SPS; i++) begin : g_dec
        assign open_vec[i] = (pos_q    == PH_W'(i));
        assign shut_vec[i] = (pos_next == PH_W'(i));
    end

    // R5: offset steps by one per accepted sample
    a_r5_pos_step: assert property (@(posedge clk) disable iff (rst)
        take |=> pos == $past(pos) + PH_W'(1));

    // R7: idle cycles leave the offset alone
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(pos));

    // R5: exactly one lane closes per sample position
    a_r5_one_shut: assert property (@(posedge clk) disable iff (rst)
        $countones(shut_vec) == 1);

endmodule

// File: rtl/mpid_acc_lane.sv
module mpid_acc_lane #(
    parameter int SAMPLE_W = mpid_pkg::DEF_SAMPLE_W,
    parameter int SUM_W    = mpid_pkg::sum_width(mpid_pkg::DEF_SAMPLE_W, mpid_pkg::DEF_SPS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  mpid_pkg::lane_ctl_t        ctl,
    input  logic signed [SAMPLE_W-1:0] data,
    output logic signed [SUM_W-1:0]    total,
    output logic                       primed
);
    logic signed [SUM_W-1:0] acc_q;
    logic                    primed_q;

    // sum including the current sample, used when the window closes
    assign total  = acc_q + SUM_W'(data);
    assign primed = primed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            primed_q <= 1'b0;
        end else if (ctl.take) begin
            if (ctl.shut) acc_q <= '0;
            else          acc_q <= total;
            if (ctl.open) primed_q <= 1'b1;
        end
    end

    // R4: a closed window leaves an empty accumulator
    a_r4_dump_clears: assert property (@(posedge clk) disable iff (rst)
        ctl.take && ctl.shut |=> acc_q == '0);

    // R8: after a reset cycle the lane is unprimed
    a_r8_reset_unprimed: assert property (@(posedge clk)
        rst |=> !primed_q);

endmodule

// File: rtl/mpid_dump_sel.sv
module mpid_dump_sel #(
    parameter int SPS   = mpid_pkg::DEF_SPS,
    parameter int SUM_W = mpid_pkg::sum_width(mpid_pkg::DEF_SAMPLE_W, mpid_pkg::DEF_SPS),
    localparam int PH_W = $clog2(SPS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    take,
    input  logic [PH_W-1:0]         pos,
    input  logic signed [SUM_W-1:0] totals [SPS],
    input  logic [SPS-1:0]          primed,
    output logic                    res_valid,
    output logic signed [SUM_W-1:0] res_sum,
    output logic [PH_W-1:0]         res_phase
);
    logic [PH_W-1:0]         sel;
    logic signed [SUM_W-1:0] sel_sum;
    logic                    sel_primed;

    assign sel        = pos + PH_W'(1);
    assign sel_sum    = totals[sel];
    assign sel_primed = primed[sel];

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_sum   <= '0;
            res_phase <= '0;
        end else begin
            res_valid <= take && sel_primed;
            if (take) begin
                res_sum   <= sel_sum;
                res_phase <= sel;
            end
        end
    end

    // R6: an unprimed lane never reports
    a_r6_primed_only: assert property (@(posedge clk) disable iff (rst)
        take && !sel_primed |=> !res_valid);

endmodule

// File: rtl/multiphase_intdump.sv
module multiphase_intdump #(
    parameter int SAMPLE_W = mpid_pkg::DEF_SAMPLE_W,
    parameter int SPS      = mpid_pkg::DEF_SPS,
    localparam int PH_W    = $clog2(SPS),
    localparam int SUM_W   = SAMPLE_W + PH_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       smp_valid,
    input  logic signed [SAMPLE_W-1:0] smp_data,
    output logic                       res_valid,
    output logic signed [SUM_W-1:0]    res_sum,
    output logic [PH_W-1:0]            res_phase
);
    logic [PH_W-1:0]         pos;
    logic [SPS-1:0]          open_vec;
    logic [SPS-1:0]          shut_vec;
    logic [SPS-1:0]          primed;
    logic signed [SUM_W-1:0] totals [SPS];

    mpid_phase_ctr #(.SPS(SPS)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .take     (smp_valid),
        .pos      (pos),
        .open_vec (open_vec),
        .shut_vec (shut_vec)
    );

    for (genvar i = 0; i < SPS; i++) begin : g_lane
        mpid_pkg::lane_ctl_t ctl;
        assign ctl.take = smp_valid;
        assign ctl.open = open_vec[i];
        assign ctl.shut = shut_vec[i];

        mpid_acc_lane #(.SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .ctl    (ctl),
            .data   (smp_data),
            .total  (totals[i]),
            .primed (primed[i])
        );
    end

    mpid_dump_sel #(.SPS(SPS), .SUM_W(SUM_W)) u_sel (
        .clk       (clk),
        .rst       (rst),
        .take      (smp_valid),
        .pos       (pos),
        .totals    (totals),
        .primed    (primed),
        .res_valid (res_valid),
        .res_sum   (res_sum),
        .res_phase (res_phase)
    );

    // R2: results only follow an accepted sample
    a_r2_after_sample: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(smp_valid));

    // R1: output quiet right after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> !res_valid);

endmodule

// File: tb/multiphase_intdump_tb_top.sv
`timescale 1ns/1ps
module multiphase_intdump_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_valid = 1'b0;
    logic signed [15:0] smp_data = '0;
    logic res_valid;
    logic signed [18:0] res_sum;
    logic [2:0] res_phase;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    multiphase_intdump dut_i (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .res_valid(res_valid), .res_sum(res_sum), .res_phase(res_phase)
    );

    // reference model
    int hist [8];
    int nacc = 0;
    logic exp_valid = 1'b0;
    int exp_sum = 0;
    int exp_phase = 0;
    string cur_tag = "R4";

    localparam int NV = 24;
    localparam logic signed [15:0] VEC [NV] = '{
        16'sd100, -16'sd50, 16'sd7, 16'sd1000, -16'sd2000, 16'sd3, 16'sd0, 16'sd12345,
        -16'sd1, -16'sd2, -16'sd3, 16'sd32767, -16'sd32768, 16'sd500, 16'sd250, -16'sd125,
        16'sd9, 16'sd8, 16'sd7, 16'sd6, -16'sd30000, 16'sd30000, 16'sd11, -16'sd4
    };

    task automatic check_out();
        checks++;
        if (res_valid !== exp_valid) begin
            errors++;
            $display("FAIL %s res_valid act=%0b exp=%0b", cur_tag, res_valid, exp_valid);
        end else if (exp_valid) begin
            if (res_sum !== 19'(exp_sum)) begin
                errors++;
                $display("FAIL %s res_sum act=%0d exp=%0d", cur_tag, res_sum, exp_sum);
            end
            if (res_phase !== 3'(exp_phase)) begin
                errors++;
                $display("FAIL R5 res_phase act=%0d exp=%0d", res_phase, exp_phase);
            end
        end
    endtask

    task automatic step(input logic v, input logic signed [15:0] x);
        check_out();
        smp_valid = v;
        smp_data  = x;
        exp_valid = 1'b0;
        if (v) begin
            hist[nacc % 8] = int'(x);
            nacc++;
            if (nacc >= 8) begin
                exp_valid = 1'b1;
                exp_sum = 0;
                for (int k = 0; k < 8; k++) exp_sum += hist[k];
                exp_phase = (nacc - 8) % 8;
            end
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        smp_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 res_valid in reset act=%0b exp=0", res_valid);
        end
        @(negedge clk);
        rst = 1'b0;
        nacc = 0;
        exp_valid = 1'b0;
        for (int k = 0; k < 8; k++) hist[k] = 0;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired act=hung exp=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        cur_tag = "R1";
        do_reset();
        step(1'b0, 16'sd0);

        // R6 and R4 / R5: table walk, back to back
        cur_tag = "R6";
        for (int i = 0; i < 7; i++) step(1'b1, VEC[i]);
        cur_tag = "R4";
        for (int i = 7; i < NV; i++) step(1'b1, VEC[i]);
        step(1'b0, 16'sd0);

        // R7: idle cycles carrying junk between valid samples
        cur_tag = "R7";
        for (int i = 0; i < 20; i++) begin
            step(1'b1, 16'(i * 311 - 3000));
            step(1'b0, 16'sh7abc);
            if (i % 3 == 0) step(1'b0, -16'sd32768);
        end
        step(1'b0, 16'sd0);

        // R3: full-scale positive, then negative
        cur_tag = "R3";
        do_reset();
        for (int i = 0; i < 8; i++) step(1'b1, 16'sd32767);
        checks++;
        if (!(res_valid && res_sum == 19'sd262136)) begin
            errors++;
            $display("FAIL R3 positive full scale act=%0d exp=262136", res_sum);
        end
        for (int i = 0; i < 8; i++) step(1'b1, -16'sd32768);
        checks++;
        if (!(res_valid && res_sum == -19'sd262144)) begin
            errors++;
            $display("FAIL R3 negative full scale act=%0d exp=-262144", res_sum);
        end
        step(1'b0, 16'sd0);

        // R8: reset mid-window, start-up gap must reappear
        cur_tag = "R8";
        for (int i = 0; i < 5; i++) step(1'b1, 16'(1000 + i));
        do_reset();
        for (int i = 0; i < 7; i++) step(1'b1, 16'(i + 1));
        cur_tag = "R2";
        for (int i = 0; i < 10; i++) step(1'b1, 16'(-i * 77));
        step(1'b0, 16'sd0);
        step(1'b0, 16'sd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule